// File: doc/BRIEF.md
# Error-Action Command Retry Sequencer

This block supervises one disk command at a time on behalf of a command issuer. Once a command is launched it waits for the controller's completion report and reads the upper nibble of the 8-bit completion code as a recovery class. The class decides what happens next. The command may finish as a success or as a failure. It may be reissued as it stands. It may first have the controller reset and then be reissued.

Each command has a limited number of attempts. A command that stays silent for too long is treated like a completion that asks for a reset and a retry. A controller reset that does not finish in its allowed window ends the command as a failure. Codes in the fatal range also end the command, and they raise a flag that only a block reset clears.

The issuer sends the first issue itself when it pulses the start strobe. After that it reacts to the reissue and reset-request outputs and waits for the done pulse, which carries a pass/fail bit and the last code seen.

Top module: `retry_sequencer`

## Requirements
- R1: When a command is waiting, a completion whose bits 7:4 are 0x0 or 0x3 gives, one cycle later, a single-cycle `done` with `done_ok`=1 and `done_code` equal to the completion code. There is no reissue and no reset request.
- R2: When a command is waiting, a completion of class 0x1, 0x2 or 0x9 ends it in the next cycle with `done`=1, `done_ok`=0 and the code. There is no reissue, whatever attempts remain.
- R3: A completion of class 0x4, when attempts remain, gives a `reissue` pulse exactly one cycle wide in the next cycle, and the attempt count rises by one.
- R4: A completion of class 0x6, when attempts remain, raises `ctl_reset_req` in the next cycle and holds it until `ctl_reset_done` is sampled high. In the cycle after that, `ctl_reset_req` is low and `reissue` pulses.
- R5: A command gets at most MAX_ATTEMPTS attempts in total, counting the first issue. A class 0x4 or 0x6 completion, or a timeout, on the last attempt ends the command with `done_ok`=0.
- R6: If no completion arrives within TIMEOUT_CYC cycles of an issue, the block follows the reset-then-retry path of R4. If the budget is spent, it ends the command with `done_ok`=0 and `done_code`=TMO_CODE (default 0x6F).
- R7: If `ctl_reset_done` has not come RESET_WAIT_CYC cycles after `ctl_reset_req` rose, `ctl_reset_req` drops and the command ends with `done_ok`=0 and the last code.
- R8: A completion code of 0xE0 or above ends the command with `done_ok`=0 and sets `fatal`. `fatal` stays set across later commands until `rst`.
- R9: Any other class (0x5, 0x7, 0x8, 0xA to 0xD) ends the command with `done_ok`=0 and no retry.
- R10: `cmd_start` while a command is in flight has no effect, so the attempt count is not reset. `cmpl_valid` while idle produces no output.
- R11: While `rst` is high, and right after it, every output is 0.
- R12: `done` is never high in the same cycle as `reissue` or `ctl_reset_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Pulse: a new command was issued |
| cmpl_valid | input | 1 | Pulse: controller reported completion |
| cmpl_code | input | 8 | Completion code, class in bits 7:4 |
| ctl_reset_done | input | 1 | Controller reset has finished |
| reissue | output | 1 | Pulse: issue the same command again |
| ctl_reset_req | output | 1 | Level: reset the controller |
| done | output | 1 | Pulse: command finished |
| done_ok | output | 1 | Valid with `done`: 1 = success |
| done_code | output | 8 | Valid with `done`: last code (or TMO_CODE) |
| fatal | output | 1 | Sticky fatal-error flag |

## Verification
The assertions assume that strobes last one cycle. They also assume that `ctl_reset_done` comes only while a reset has been requested. The stimulus follows this: each strobe is driven for one cycle, and `ctl_reset_done` is raised only after `ctl_reset_req` has been seen high, except in the reset-wait expiry test, where it is never raised at all. The ignored-input cases (a start while busy, a completion while idle) are still driven on purpose, and their effect is judged at the outputs.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    ACT_PASS,
    ACT_REJECT,
    ACT_REISSUE,
    ACT_RESET,
    ACT_FATAL
  } act_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RST
  } st_e;
endpackage

// File: rtl/rseq_classify.sv
module rseq_classify
  import rseq_pkg::*;
(
  input  logic [7:0] code,
  output act_e       act
);
  always_comb begin
    if (code[7:5] == 3'b111) begin
      act = ACT_FATAL;
    end else begin
      case (code[7:4])
        4'h0, 4'h3: act = ACT_PASS;
        4'h4:       act = ACT_REISSUE;
        4'h6:       act = ACT_RESET;
        default:    act = ACT_REJECT;
      endcase
    end
  end
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + W'(1);
    end
  end

  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/retry_sequencer.sv
module retry_sequencer
  import rseq_pkg::*;
#(
  parameter int         MAX_ATTEMPTS   = 4,
  parameter int         TIMEOUT_CYC    = 800000000,
  parameter int         RESET_WAIT_CYC = 200000000,
  parameter logic [7:0] TMO_CODE       = 8'h6F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_start,
  input  logic       cmpl_valid,
  input  logic [7:0] cmpl_code,
  input  logic       ctl_reset_done,
  output logic       reissue,
  output logic       ctl_reset_req,
  output logic       done,
  output logic       done_ok,
  output logic [7:0] done_code,
  output logic       fatal
);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [AW-1:0] MAX_A = AW'(MAX_ATTEMPTS);

  st_e           st;
  act_e          act;
  logic [AW-1:0] attempts;
  logic [7:0]    last_code;
  logic          budget_left;
  logic          tmo_exp;
  logic          rw_exp;

  assign budget_left = attempts < MAX_A;

  rseq_classify u_cls (
    .code (cmpl_code),
    .act  (act)
  );

  rseq_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .clr     ((st != ST_WAIT) || cmpl_valid),
    .run     ((st == ST_WAIT) && !cmpl_valid),
    .expired (tmo_exp)
  );

  rseq_timer #(.LIMIT(RESET_WAIT_CYC)) u_rw (
    .clk     (clk),
    .rst     (rst),
    .clr     (st != ST_RST),
    .run     ((st == ST_RST) && !ctl_reset_done),
    .expired (rw_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      attempts      <= '0;
      last_code     <= '0;
      reissue       <= 1'b0;
      ctl_reset_req <= 1'b0;
      done          <= 1'b0;
      done_ok       <= 1'b0;
      done_code     <= '0;
      fatal         <= 1'b0;
    end else begin
      reissue <= 1'b0;
      done    <= 1'b0;
      done_ok <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (cmd_start) begin
            st       <= ST_WAIT;
            attempts <= AW'(1);
          end
        end
        ST_WAIT: begin
          if (cmpl_valid) begin
            last_code <= cmpl_code;
            case (act)
              ACT_PASS: begin
                done      <= 1'b1;
                done_ok   <= 1'b1;
                done_code <= cmpl_code;
                st        <= ST_IDLE;
              end
              ACT_REISSUE: begin
                if (budget_left) begin
                  reissue  <= 1'b1;
                  attempts <= attempts + AW'(1);
                end else begin
                  done      <= 1'b1;
                  done_code <= cmpl_code;
                  st        <= ST_IDLE;
                end
              end
              ACT_RESET: begin
                if (budget_left) begin
                  ctl_reset_req <= 1'b1;
                  st            <= ST_RST;
                end else begin
                  done      <= 1'b1;
                  done_code <= cmpl_code;
                  st        <= ST_IDLE;
                end
              end
              ACT_FATAL: begin
                fatal     <= 1'b1;
                done      <= 1'b1;
                done_code <= cmpl_code;
                st        <= ST_IDLE;
              end
              default: begin
                done      <= 1'b1;
                done_code <= cmpl_code;
                st        <= ST_IDLE;
              end
            endcase
          end else if (tmo_exp) begin
            last_code <= TMO_CODE;
            if (budget_left) begin
              ctl_reset_req <= 1'b1;
              st            <= ST_RST;
            end else begin
              done      <= 1'b1;
              done_code <= TMO_CODE;
              st        <= ST_IDLE;
            end
          end
        end
        ST_RST: begin
          if (ctl_reset_done) begin
            ctl_reset_req <= 1'b0;
            reissue       <= 1'b1;
            attempts      <= attempts + AW'(1);
            st            <= ST_WAIT;
          end else if (rw_exp) begin
            ctl_reset_req <= 1'b0;
            done          <= 1'b1;
            done_code     <= last_code;
            st            <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R12
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!reissue && !ctl_reset_req));

  // R5
  attempt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    attempts <= MAX_A);

  // R8
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fatal) && !$past(rst)) |-> fatal);

  // R4
  rst_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_reset_req) |-> (reissue || (done && !done_ok)));

  // R1
  ok_class_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_ok) |-> (done_code[7:4] == 4'h0 || done_code[7:4] == 4'h3));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!reissue && !ctl_reset_req));
endmodule

// File: tb/test_retry_sequencer.sv
module test_retry_sequencer;
  localparam int TMO = 20;
  localparam int RW  = 15;
  localparam int NV  = 13;

  // {count, c0, c1, c2, c3, ok, reissues, resets, final code}
  localparam logic [55:0] VEC [NV] = '{
    56'h1_00000000_1_0_0_00, // R1
    56'h1_33000000_1_0_0_33, // R1
    56'h1_12000000_0_0_0_12, // R2
    56'h1_25000000_0_0_0_25, // R2
    56'h1_91000000_0_0_0_91, // R2
    56'h2_41000000_1_1_0_00, // R3
    56'h4_41424344_0_3_0_44, // R5
    56'h2_60000000_1_1_1_00, // R4
    56'h4_61416230_1_3_2_30, // R4 R5
    56'h4_62626262_0_3_3_62, // R5
    56'h1_A5000000_0_0_0_A5, // R9
    56'h1_50000000_0_0_0_50, // R9
    56'h2_41130000_0_1_0_13  // R2 R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_start = 1'b0, cmpl_valid = 1'b0, ctl_reset_done = 1'b0;
  logic [7:0] cmpl_code = '0;
  logic reissue, ctl_reset_req, done, done_ok, fatal;
  logic [7:0] done_code;

  int total = 0, bad = 0;
  int n_re = 0, n_rs = 0, n_done = 0;
  logic prev_req = 1'b0, last_ok = 1'b0;
  logic [7:0] last_code = '0;

  always #2.5 clk = ~clk;

  retry_sequencer #(.MAX_ATTEMPTS(4), .TIMEOUT_CYC(TMO), .RESET_WAIT_CYC(RW))
  i_retry_sequencer (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmpl_valid(cmpl_valid),
    .cmpl_code(cmpl_code), .ctl_reset_done(ctl_reset_done),
    .reissue(reissue), .ctl_reset_req(ctl_reset_req), .done(done),
    .done_ok(done_ok), .done_code(done_code), .fatal(fatal)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (reissue) n_re++;
      if (ctl_reset_req && !prev_req) n_rs++;
      if (done) begin
        n_done++;
        last_ok   = done_ok;
        last_code = done_code;
      end
    end
    prev_req = ctl_reset_req;
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_re = 0; n_rs = 0; n_done = 0;
  endtask

  task automatic complete(input logic [7:0] c);
    cmpl_valid = 1'b1; cmpl_code = c;
    step();
    cmpl_valid = 1'b0;
  endtask

  task automatic start();
    cmd_start = 1'b1;
    step();
    cmd_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();
    // R11 outputs during reset
    chk("R11 outputs in reset", {reissue, ctl_reset_req, done, done_ok, fatal, done_code}, '0);
    rst = 1'b0;
    step();
    chk("R11 outputs after reset", {reissue, ctl_reset_req, done, done_ok, fatal, done_code}, '0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      clear_mon();
      start();
      for (int i = 0; i < int'(VEC[v][55:52]); i++) begin
        complete(VEC[v][51 - 8*i -: 8]);
        if (ctl_reset_req) begin
          ctl_reset_done = 1'b1;
          step();
          ctl_reset_done = 1'b0;
        end
      end
      step();
      chk($sformatf("R1/R2/R3/R4/R5/R9 vector %0d done count", v), n_done, 1);
      chk($sformatf("R1/R2/R9 vector %0d ok", v), last_ok, VEC[v][16]);
      chk($sformatf("R3/R5 vector %0d reissues", v), n_re, VEC[v][15:12]);
      chk($sformatf("R4 vector %0d resets", v), n_rs, VEC[v][11:8]);
      chk($sformatf("R1/R5 vector %0d code", v), last_code, VEC[v][7:0]);
    end

    // R10 completion while idle is ignored
    clear_mon();
    complete(8'h00);
    step();
    chk("R10 completion in idle gives no done", n_done, 0);

    // R3 pulse timing, R10 start while busy does not refill budget
    clear_mon();
    start();
    complete(8'h41);
    chk("R3 reissue next cycle", reissue, 1);
    step();
    chk("R3 reissue is one cycle", reissue, 0);
    start();
    complete(8'h41);
    start();
    complete(8'h41);
    complete(8'h41);
    step();
    chk("R10 busy start ignored reissues", n_re, 3);
    chk("R10 busy start ignored ends fail", {n_done[7:0], last_ok, last_code}, {8'd1, 1'b0, 8'h41});

    // R6 timeout exact cycle, then reset path R4
    clear_mon();
    start();
    repeat (TMO - 1) step();
    chk("R6 no reset before timeout", ctl_reset_req, 0);
    step();
    chk("R6 reset at timeout", ctl_reset_req, 1);
    step();
    chk("R4 reset held until done", ctl_reset_req, 1);
    ctl_reset_done = 1'b1;
    step();
    ctl_reset_done = 1'b0;
    chk("R4 reissue after reset done", {reissue, ctl_reset_req}, 2'b10);
    complete(8'h00);
    chk("R6 recovered command ok", {done, done_ok}, 2'b11);
    step();
    chk("R12 done is one cycle", done, 0);

    // R6 repeated timeouts exhaust budget
    clear_mon();
    start();
    for (int k = 0; k < 3; k++) begin
      repeat (TMO) step();
      chk("R6 timeout reset request", ctl_reset_req, 1);
      ctl_reset_done = 1'b1;
      step();
      ctl_reset_done = 1'b0;
    end
    repeat (TMO - 1) step();
    chk("R6 last attempt still waiting", done, 0);
    step();
    chk("R6 timeout on last attempt fails", {done, done_ok, ctl_reset_req, done_code}, {3'b100, 8'h6F});

    // R7 reset wait expiry
    clear_mon();
    start();
    complete(8'h60);
    chk("R7 reset requested", ctl_reset_req, 1);
    repeat (RW - 1) step();
    chk("R7 still waiting for reset", {ctl_reset_req, done}, 2'b10);
    step();
    chk("R7 reset wait expired fails", {done, done_ok, ctl_reset_req, done_code}, {3'b100, 8'h60});

    // R8 fatal code and stickiness
    start();
    complete(8'hE3);
    chk("R8 fatal ends fail", {done, done_ok, fatal, done_code}, {3'b101, 8'hE3});
    start();
    complete(8'h00);
    chk("R8 fatal sticky across command", {done, done_ok, fatal}, 3'b111);
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    step();
    chk("R8 R11 fatal cleared by reset", fatal, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule